// File: doc/BRIEF.md
# Low-Power Mode Controller with Register-Selected Sleep Depth

This block decides how deep a processor sleeps when it issues a stop strobe. Software writes a small control register beforehand to pick the depth. The stop strobe then applies that choice. Three depths exist. In wait, the processor and memory clocks halt and the peripherals keep running. In doze, only the peripherals that software has marked to keep their clock stay active. In stop, every clock the block drives is held off.

The block leaves a low-power state on an interrupt request. Wait and doze accept any source, internal or external. Stop accepts only external sources. The return to run takes a single edge, with no settling delay. A separate power-down mask, written through the same register port, turns off individual peripheral clocks whatever the processor state. The frequency synthesizer, the peripherals and the interrupt controller sit outside the block. The block drives clock-enable outputs and reads request lines.

Top module: `lp_mode_ctrl`

## Requirements
- R1: After reset the state is run (lp_mode_o = 0), the cpu and memory enables are 1, all peripheral enables are 1, and every register reads 0.
- R2: A write with reg_we_i at 1 takes effect at the next edge. Address 0 holds the 2-bit depth field in bits [1:0] and reads 0 above them. Address 1 holds the doze keep mask and address 2 the power-down mask, one bit per peripheral. Address 3 ignores writes and reads 0. Reads are combinational.
- R3: stop_i at 1 in run moves the state at the next edge according to the depth field held before that edge. Field value 0 gives wait (lp_mode_o = 1), 1 gives doze (2), 2 gives stop (3), and 3 gives wait.
- R4: stop_i at 1 while the state is not run has no effect on the state.
- R5: In wait, cpu_clk_en_o and mem_clk_en_o are 0 and peripheral bit i is 1 exactly when power-down bit i is 0.
- R6: In doze, cpu and memory enables are 0 and peripheral bit i is 1 exactly when keep bit i is 1 and power-down bit i is 0.
- R7: In stop, the cpu, memory and all peripheral enables are 0.
- R8: In wait or doze, any internal or external request bit at 1 returns the state to run at the next edge.
- R9: In stop, internal requests are ignored, and any external request bit at 1 returns the state to run at the next edge.
- R10: In run, cpu and memory enables are 1 and peripheral bit i is the inverse of power-down bit i. This holds for every depth field value.
- R11: Every enable output comes from a register. It updates on the same edge as the state and the register contents it depends on, so it always matches the present state and registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-running clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | NUM_PERIPH | Write data |
| reg_rdata_o | output | NUM_PERIPH | Read data for reg_addr_i |
| stop_i | input | 1 | Stop strobe from the processor |
| int_irq_i | input | NUM_INT | Internal interrupt requests |
| ext_irq_i | input | NUM_EXT | External interrupt requests |
| cpu_clk_en_o | output | 1 | Processor clock enable |
| mem_clk_en_o | output | 1 | Memory clock enable |
| periph_clk_en_o | output | NUM_PERIPH | Per-peripheral clock enables |
| lp_mode_o | output | 2 | State: 0 run, 1 wait, 2 doze, 3 stop |

## Verification
Embedded assertions check several properties on every cycle. Each stop strobe in run leaves run. A wake request in wait or doze returns to run. Stop holds while no external request is present. The enable outputs respect the active state: off in stop, restricted to the keep mask in doze, and processor and memory off outside run. Only the bench's scenarios show the rest. These are the choice of depth for each field value, including the spare encoding, and the exact mask arithmetic. They also cover register readback and the cases where a strobe or request must have no effect. A behavioural model compares every output on every cycle through directed and random sequences.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_DOZE = 2'd2,
    ST_STOP = 2'd3
  } lp_state_e;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_KEEP = 2'd1;
  localparam logic [1:0] ADDR_PD   = 2'd2;

  // spare encoding 3 falls back to wait
  function automatic lp_state_e depth_sel(input logic [1:0] fld);
    case (fld)
      2'd1:    return ST_DOZE;
      2'd2:    return ST_STOP;
      default: return ST_WAIT;
    endcase
  endfunction
endpackage

// File: rtl/lpm_regs.sv
module lpm_regs
  import lpm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [1:0]    mode_q_o,
  output logic [DW-1:0] keep_q_o,
  output logic [DW-1:0] pd_q_o,
  output logic [DW-1:0] keep_d_o,
  output logic [DW-1:0] pd_d_o
);
  logic [1:0]    mode_q, mode_d;
  logic [DW-1:0] keep_q, keep_d, pd_q, pd_d;

  always_comb begin
    mode_d = mode_q;
    keep_d = keep_q;
    pd_d   = pd_q;
    if (we_i) begin
      case (addr_i)
        ADDR_MODE: mode_d = wdata_i[1:0];
        ADDR_KEEP: keep_d = wdata_i;
        ADDR_PD:   pd_d   = wdata_i;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      keep_q <= '0;
      pd_q   <= '0;
    end else begin
      mode_q <= mode_d;
      keep_q <= keep_d;
      pd_q   <= pd_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_MODE: rdata_o[1:0] = mode_q;
      ADDR_KEEP: rdata_o = keep_q;
      ADDR_PD:   rdata_o = pd_q;
      default:   ;
    endcase
  end

  assign mode_q_o = mode_q;
  assign keep_q_o = keep_q;
  assign pd_q_o   = pd_q;
  assign keep_d_o = keep_d;
  assign pd_d_o   = pd_d;

  a_r2_mode_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_MODE) |=> mode_q == $past(wdata_i[1:0]));
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int NI = 4,
  parameter int NE = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stop_i,
  input  logic [1:0]    mode_fld_i,
  input  logic [NI-1:0] int_irq_i,
  input  logic [NE-1:0] ext_irq_i,
  output lp_state_e     state_q_o,
  output lp_state_e     state_d_o
);
  lp_state_e state_q, state_d;
  logic any_int, any_ext;

  assign any_int = |int_irq_i;
  assign any_ext = |ext_irq_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:  if (stop_i) state_d = depth_sel(mode_fld_i);
      ST_WAIT,
      ST_DOZE: if (any_int || any_ext) state_d = ST_RUN;
      ST_STOP: if (any_ext) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;

  a_r3_leave_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && stop_i) |=> state_q != ST_RUN);
  a_r8_wake_light: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WAIT || state_q == ST_DOZE) && (any_int || any_ext)) |=> state_q == ST_RUN);
  a_r9_stop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && !any_ext) |=> state_q == ST_STOP);
  a_r4_no_reenter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_RUN && state_d != ST_RUN) |=> $stable(state_q));
endmodule

// File: rtl/lpm_clk_en.sv
module lpm_clk_en
  import lpm_pkg::*;
#(
  parameter int NP = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  lp_state_e     state_d_i,
  input  logic [NP-1:0] keep_d_i,
  input  logic [NP-1:0] pd_d_i,
  input  lp_state_e     state_q_i,
  input  logic [NP-1:0] keep_q_i,
  output logic          cpu_en_o,
  output logic          mem_en_o,
  output logic [NP-1:0] periph_en_o
);
  logic core_on;
  assign core_on = (state_d_i == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_en_o <= 1'b1;
      mem_en_o <= 1'b1;
    end else begin
      cpu_en_o <= core_on;
      mem_en_o <= core_on;
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_periph
    logic on_d;
    always_comb begin
      case (state_d_i)
        ST_RUN, ST_WAIT: on_d = ~pd_d_i[g];
        ST_DOZE:         on_d = ~pd_d_i[g] & keep_d_i[g];
        default:         on_d = 1'b0;
      endcase
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) periph_en_o[g] <= 1'b1;
      else         periph_en_o[g] <= on_d;
    end
  end

  a_r7_stop_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q_i == ST_STOP) |-> (periph_en_o == '0 && !cpu_en_o && !mem_en_o));
  a_r6_doze_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q_i == ST_DOZE) |-> ((periph_en_o & ~keep_q_i) == '0));
  a_r5_core_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q_i != ST_RUN) |-> (!cpu_en_o && !mem_en_o));
  a_r11_core_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q_i == ST_RUN) |-> (cpu_en_o && mem_en_o));
endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_PERIPH = 8,
  parameter int NUM_INT    = 4,
  parameter int NUM_EXT    = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [1:0]            reg_addr_i,
  input  logic [NUM_PERIPH-1:0] reg_wdata_i,
  output logic [NUM_PERIPH-1:0] reg_rdata_o,
  input  logic                  stop_i,
  input  logic [NUM_INT-1:0]    int_irq_i,
  input  logic [NUM_EXT-1:0]    ext_irq_i,
  output logic                  cpu_clk_en_o,
  output logic                  mem_clk_en_o,
  output logic [NUM_PERIPH-1:0] periph_clk_en_o,
  output logic [1:0]            lp_mode_o
);
  logic [1:0]            mode_fld;
  logic [NUM_PERIPH-1:0] keep_q, pd_q, keep_d, pd_d;
  lp_state_e             state_q, state_d;

  lpm_regs #(.DW(NUM_PERIPH)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .mode_q_o(mode_fld),
    .keep_q_o(keep_q), .pd_q_o(pd_q), .keep_d_o(keep_d), .pd_d_o(pd_d)
  );

  lpm_fsm #(.NI(NUM_INT), .NE(NUM_EXT)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .stop_i(stop_i), .mode_fld_i(mode_fld),
    .int_irq_i(int_irq_i), .ext_irq_i(ext_irq_i),
    .state_q_o(state_q), .state_d_o(state_d)
  );

  lpm_clk_en #(.NP(NUM_PERIPH)) u_clk_en (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_d_i(state_d), .keep_d_i(keep_d),
    .pd_d_i(pd_d), .state_q_i(state_q), .keep_q_i(keep_q),
    .cpu_en_o(cpu_clk_en_o), .mem_en_o(mem_clk_en_o), .periph_en_o(periph_clk_en_o)
  );

  assign lp_mode_o = state_q;

  a_r10_run_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_mode_o == 2'd0) |-> (periph_clk_en_o == ~pd_q));
endmodule

// File: tb/lp_mode_ctrl_tb.sv
module lp_mode_ctrl_tb_top;
  localparam int NP = 8;
  localparam int NI = 4;
  localparam int NE = 2;

  logic clk = 0, rst_n = 0;
  logic we = 0, stop = 0;
  logic [1:0] addr = 0;
  logic [NP-1:0] wdata = 0;
  logic [NI-1:0] iirq = 0;
  logic [NE-1:0] eirq = 0;
  logic [NP-1:0] rdata, pen;
  logic cpu_en, mem_en;
  logic [1:0] mode;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lp_mode_ctrl #(.NUM_PERIPH(NP), .NUM_INT(NI), .NUM_EXT(NE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .stop_i(stop),
    .int_irq_i(iirq), .ext_irq_i(eirq), .cpu_clk_en_o(cpu_en),
    .mem_clk_en_o(mem_en), .periph_clk_en_o(pen), .lp_mode_o(mode)
  );

  // behavioural reference: 0 run, 1 wait, 2 doze, 3 stop
  int m_state, m_fld;
  logic [NP-1:0] m_keep, m_pd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_fld = 0; m_keep = 0; m_pd = 0;
    end else begin
      int nxt;
      nxt = m_state;
      if (m_state == 0 && stop) nxt = (m_fld == 1) ? 2 : (m_fld == 2) ? 3 : 1;
      else if ((m_state == 1 || m_state == 2) && (iirq != 0 || eirq != 0)) nxt = 0;
      else if (m_state == 3 && eirq != 0) nxt = 0;
      m_state = nxt;
      if (we) begin
        if (addr == 0) m_fld = int'(wdata[1:0]);
        if (addr == 1) m_keep = wdata;
        if (addr == 2) m_pd = wdata;
      end
    end
  end

  function automatic logic [NP-1:0] exp_pen();
    case (m_state)
      0, 1: return ~m_pd;
      2:    return ~m_pd & m_keep;
      default: return '0;
    endcase
  endfunction

  function automatic logic [NP-1:0] exp_rdata();
    case (addr)
      2'd0: return NP'(m_fld);
      2'd1: return m_keep;
      2'd2: return m_pd;
      default: return '0;
    endcase
  endfunction

  function automatic string st_tag();
    case (m_state)
      0: return "R10";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model (R11: enables track state and registers)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(32'(mode), 32'(m_state), "R3 R8 R9 state");
      chk(32'(cpu_en), 32'(m_state == 0), {st_tag(), " R11 cpu"});
      chk(32'(mem_en), 32'(m_state == 0), {st_tag(), " R11 mem"});
      chk(32'(pen), 32'(exp_pen()), {st_tag(), " R11 periph"});
      chk(32'(rdata), 32'(exp_rdata()), "R2 rdata");
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [NP-1:0] d);
    we = 1; addr = a; wdata = d; step(); we = 0;
  endtask

  task automatic pulse_stop();
    stop = 1; step(); stop = 0;
  endtask

  task automatic look(input logic [1:0] exp_mode, input string tag);
    @(negedge clk);
    chk(32'(mode), 32'(exp_mode), tag);
    #1;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #35 rst_n = 1;
    step();
    // R1 reset state
    @(negedge clk);
    chk(32'(mode), 0, "R1 mode");
    chk(32'({cpu_en, mem_en}), 3, "R1 core enables");
    chk(32'(pen), 32'({NP{1'b1}}), "R1 periph");
    chk(32'(rdata), 0, "R1 regs");
    step();
    // R2 register access including unused address
    wr(2'd3, 8'hff); addr = 2'd3; @(negedge clk); chk(32'(rdata), 0, "R2 addr3");
    step();
    wr(2'd0, 8'hfe); addr = 2'd0; @(negedge clk); chk(32'(rdata), 2, "R2 mode field");
    step();
    // R10 power-down mask in run
    wr(2'd2, 8'h0f); @(negedge clk); chk(32'(pen), 32'h0f0, "R10 pd in run");
    step();
    wr(2'd1, 8'h3c);
    // R3 field 2 -> stop; R7 all dark
    pulse_stop(); look(2'd3, "R3 stop entry");
    chk(32'(pen), 0, "R7 periph off");
    // R4 strobe ignored, R9 internal ignored
    stop = 1; iirq = 4'h5; step(); stop = 0; iirq = 0;
    look(2'd3, "R4 R9 hold in stop");
    eirq = 2'b10; step(); eirq = 0; look(2'd0, "R9 external wake");
    // R3 field 1 -> doze; R6 mask
    wr(2'd0, 8'd1); pulse_stop(); look(2'd2, "R3 doze entry");
    chk(32'(pen), 32'h30, "R6 doze periph");
    stop = 1; step(); stop = 0; look(2'd2, "R4 doze hold");
    iirq = 4'h8; step(); iirq = 0; look(2'd0, "R8 internal wake doze");
    // R3 field 0 -> wait; R5
    wr(2'd0, 8'd0); pulse_stop(); look(2'd1, "R3 wait entry");
    chk(32'(pen), 32'hf0, "R5 wait periph");
    eirq = 2'b01; step(); eirq = 0; look(2'd0, "R8 external wake wait");
    // R3 spare encoding -> wait
    wr(2'd0, 8'd3); pulse_stop(); look(2'd1, "R3 spare to wait");
    iirq = 4'h1; step(); iirq = 0; look(2'd0, "R8 wake");
    // R3 field written in the strobe cycle: old value applies
    wr(2'd0, 8'd2);
    we = 1; addr = 2'd0; wdata = 8'd1; stop = 1; step(); we = 0; stop = 0;
    look(2'd3, "R3 old field used");
    eirq = 2'b11; step(); eirq = 0;
    // random sequence, compared by the model every cycle
    for (int i = 0; i < 600; i++) begin
      we    = ($urandom % 4) == 0;
      addr  = 2'($urandom);
      wdata = NP'($urandom);
      stop  = ($urandom % 5) == 0;
      iirq  = (($urandom % 6) == 0) ? NI'($urandom) : '0;
      eirq  = (($urandom % 9) == 0) ? NE'($urandom) : '0;
      step();
    end
    we = 0; stop = 0; iirq = 0; eirq = 0;
    step(); step();
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule